// File: doc/BRIEF.md
# Interrupt Status Register Controller

This block holds a chip's interrupt status word and the matching enable word, both reachable through a small host register port. Event sources are single-cycle pulses: a master bus error, a slave bus error, one pulse per general-purpose pin and a timer wrap. Each pulse sets its own sticky status bit. The host clears a sticky bit by writing a 1 to its position. A separate software interrupt bit sets when the host turns on bit 15 of the enable word. The external PHY interrupt is a level input. It appears in the status word as it is and can only be cleared at its source.

A soft-reset input lets the host recover from either bus error. It clears both bus-error bits without touching the other status bits. The enabled status bits are ORed together and registered to drive a single interrupt line. The host port is a plain write strobe with address and data. The read data is a combinational function of the address.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, the status word, the enable word and `irq_out` are all 0.
- R2: The status word is at byte address 0x0C8 and the enable word is at 0x0CC. In the status word, bits 31:16, 14, 11:7 and 1:0 always read 0. The enable word stores and returns only bits 15, 13, 12, 6:4, 3 and 2 (mask 0x0000B07C).
- R3: A one-cycle pulse on `mberr_pulse`, `sberr_pulse`, `gpio_pulse[i]` or `tmr_wrap` sets status bit 13, bit 12, bit 4+i or bit 3 respectively, on the clock edge where the pulse is high. The bit then stays set.
- R4: Writing the status word clears each sticky bit (15, 13, 12, 6:4, 3) whose write-data bit is 1. A sticky bit whose write-data bit is 0 keeps its value.
- R5: If a source event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R6: Status bit 15 sets on the second clock edge after the write that changes enable bit 15 from 0 to 1. While enable bit 15 stays at 1, clearing bit 15 does not cause it to set again.
- R7: Status bit 2 equals `phy_irq` in the same cycle, and writing to it has no effect.
- R8: A cycle with `soft_rst` high clears status bits 13 and 12, even if a bus error arrives in that same cycle. All other status bits are left as they were.
- R9: `irq_out` is, one clock later, the OR over all bit positions of status ANDed with enable.
- R10: A write to any address other than the two registers changes nothing, and such an address reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| soft_rst | input | 1 | Clears the bus-error status bits |
| host_addr | input | 12 | Byte address of the register access |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for `host_addr` |
| mberr_pulse | input | 1 | Master bus error event |
| sberr_pulse | input | 1 | Slave bus error event |
| gpio_pulse | input | 3 | Per-pin general-purpose interrupt events |
| tmr_wrap | input | 1 | Timer wrap-to-zero event |
| phy_irq | input | 1 | PHY interrupt level |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
The bench builds the block with its default parameters. That means three general-purpose pins, a 12-bit address and the register offsets 0x0C8 and 0x0CC. With these values every defined bit position, every reserved position and an unmapped address can all be reached from the host port. The vector table walks a sequence of events, clears and enable writes in which each step depends on the sticky state left by the steps before it. Directed tests then cover the exact cycle of the software-bit edge, the one-cycle lag of the interrupt line, soft-reset priority and the enable readback mask.

// File: rtl/irq_sts_pkg.sv
package irq_sts_pkg;
  localparam int STS_W   = 16;
  localparam int SW_BIT  = 15;
  localparam int MB_BIT  = 13;
  localparam int SB_BIT  = 12;
  localparam int GP_LSB  = 4;
  localparam int TMR_BIT = 3;
  localparam int PHY_BIT = 2;

  // next value of a sticky bit: kill beats everything, an event beats a clear
  function automatic logic sticky_next(logic cur, logic evt, logic clr, logic kill);
    return !kill && (evt || (cur && !clr));
  endfunction

  // rising edge of a level given its previous-cycle copy
  function automatic logic rise_of(logic now_v, logic prev_v);
    return now_v && !prev_v;
  endfunction
endpackage

// File: rtl/irq_rise_det.sv
module irq_rise_det
  import irq_sts_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end

  assign rise = rise_of(lvl, lvl_d);
endmodule

// File: rtl/irq_sticky_bit.sv
module irq_sticky_bit
  import irq_sts_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  input  logic kill,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= sticky_next(q, evt, clr, kill);
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sts,
  input  logic [W-1:0] en,
  output logic         irq
);
  logic any_hit;
  assign any_hit = |(sts & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= any_hit;
  end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_sts_pkg::*;
#(
  parameter int               ADDR_W   = 12,
  parameter int               DATA_W   = 32,
  parameter int               GPIO_N   = 3,
  parameter logic [ADDR_W-1:0] STS_ADDR = 12'h0C8,
  parameter logic [ADDR_W-1:0] EN_ADDR  = 12'h0CC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              mberr_pulse,
  input  logic              sberr_pulse,
  input  logic [GPIO_N-1:0] gpio_pulse,
  input  logic              tmr_wrap,
  input  logic              phy_irq,
  output logic              irq_out
);
  localparam logic [STS_W-1:0] GP_MASK    = STS_W'(((1 << GPIO_N) - 1) << GP_LSB);
  localparam logic [STS_W-1:0] STICKY_MSK = STS_W'((1 << SW_BIT) | (1 << MB_BIT) | (1 << SB_BIT)
                                                   | (1 << TMR_BIT)) | GP_MASK;
  localparam logic [STS_W-1:0] DEF_MASK   = STICKY_MSK | STS_W'(1 << PHY_BIT);
  localparam logic [STS_W-1:0] KILL_MASK  = STS_W'((1 << MB_BIT) | (1 << SB_BIT));

  logic             sts_hit, en_hit, sts_wr, en_wr;
  logic [STS_W-1:0] en_q, clr_vec, evt_vec, sticky_q, sts_vec;
  logic             sw_rise;

  assign sts_hit = (host_addr == STS_ADDR);
  assign en_hit  = (host_addr == EN_ADDR);
  assign sts_wr  = host_wr && sts_hit;
  assign en_wr   = host_wr && en_hit;
  assign clr_vec = sts_wr ? (host_wdata[STS_W-1:0] & STICKY_MSK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= host_wdata[STS_W-1:0] & DEF_MASK;
  end

  irq_rise_det u_sw_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lvl  (en_q[SW_BIT]),
    .rise (sw_rise)
  );

  always_comb begin
    evt_vec          = '0;
    evt_vec[SW_BIT]  = sw_rise;
    evt_vec[MB_BIT]  = mberr_pulse;
    evt_vec[SB_BIT]  = sberr_pulse;
    evt_vec[TMR_BIT] = tmr_wrap;
    for (int i = 0; i < GPIO_N; i++) evt_vec[GP_LSB+i] = gpio_pulse[i];
  end

  for (genvar i = 0; i < STS_W; i++) begin : g_bit
    if (STICKY_MSK[i]) begin : g_sticky
      irq_sticky_bit u_bit (
        .clk  (clk),
        .rst_n(rst_n),
        .evt  (evt_vec[i]),
        .clr  (clr_vec[i]),
        .kill (KILL_MASK[i] && soft_rst),
        .q    (sticky_q[i])
      );
    end else begin : g_tie
      assign sticky_q[i] = 1'b0;
    end
  end

  always_comb begin
    sts_vec          = sticky_q;
    sts_vec[PHY_BIT] = phy_irq;
  end

  always_comb begin
    host_rdata = '0;
    if (sts_hit)     host_rdata[STS_W-1:0] = sts_vec;
    else if (en_hit) host_rdata[STS_W-1:0] = en_q;
  end

  irq_combine #(.W(STS_W)) u_comb (
    .clk  (clk),
    .rst_n(rst_n),
    .sts  (sts_vec),
    .en   (en_q),
    .irq  (irq_out)
  );
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] STS_ADDR = 12'h0C8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic [31:0]       host_wdata,
  input logic [31:0]       host_rdata,
  input logic              mberr_pulse,
  input logic              tmr_wrap,
  input logic              phy_irq,
  input logic              irq_out,
  input logic [15:0]       sts,
  input logic [15:0]       en
);
  logic en15_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en15_d <= 1'b0;
    else        en15_d <= en[15];
  end

  logic sts_w;
  assign sts_w = host_wr && (host_addr == STS_ADDR);

  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == STS_ADDR) |-> (host_rdata[31:16] == 16'h0 && !host_rdata[14]
                                 && host_rdata[11:7] == 5'h0 && host_rdata[1:0] == 2'h0));
  // R3
  mb_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mberr_pulse && !soft_rst) |=> sts[13]);
  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_w && host_wdata[3] && !tmr_wrap) |=> !sts[3]);
  // R4
  w0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_w && !host_wdata[3] && sts[3]) |=> sts[3]);
  // R5
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_w && host_wdata[3] && tmr_wrap) |=> sts[3]);
  // R6
  sw_no_retrig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts[15] && !(en[15] && !en15_d)) |=> !sts[15]);
  // R7
  phy_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == STS_ADDR) |-> (host_rdata[2] == phy_irq));
  // R8
  soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!sts[13] && !sts[12]));
  // R9
  irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(|(sts & en))));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .STS_ADDR(STS_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .soft_rst   (soft_rst),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .mberr_pulse(mberr_pulse),
  .tmr_wrap   (tmr_wrap),
  .phy_irq    (phy_irq),
  .irq_out    (irq_out),
  .sts        (sts_vec),
  .en         (en_q)
);

// File: tb/irq_status_ctrl_bench.sv
module irq_status_ctrl_bench;
  localparam time        HALF = 2ns;
  localparam logic [11:0] A_STS = 12'h0C8;
  localparam logic [11:0] A_EN  = 12'h0CC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [11:0] host_addr = A_STS;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mberr_pulse = 1'b0, sberr_pulse = 1'b0, tmr_wrap = 1'b0, phy_irq = 1'b0;
  logic [2:0]  gpio_pulse = '0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #HALF clk = ~clk;

  irq_status_ctrl u_irq_status_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .mberr_pulse(mberr_pulse), .sberr_pulse(sberr_pulse),
    .gpio_pulse(gpio_pulse), .tmr_wrap(tmr_wrap), .phy_irq(phy_irq), .irq_out(irq_out)
  );

  typedef struct packed {
    logic        wr;
    logic        to_en;
    logic [15:0] wd;
    logic        mb;
    logic        sb;
    logic [2:0]  gp;
    logic        tmr;
    logic        phy;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 16'h0000}, // R1 idle
    '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 3'b000, 1'b0, 1'b0, 16'h2000}, // R3 master err
    '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 3'b101, 1'b0, 1'b0, 16'h3050}, // R3 slave err + gpio
    '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 3'b000, 1'b1, 1'b1, 16'h305C}, // R3 R7 timer, phy
    '{1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 16'h305C}, // R4 write zero
    '{1'b1, 1'b0, 16'h2010, 1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 16'h104C}, // R4 partial clear
    '{1'b1, 1'b0, 16'h0004, 1'b0, 1'b0, 3'b000, 1'b0, 1'b1, 16'h104C}, // R7 write phy bit
    '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 16'h1048}, // R7 phy drops
    '{1'b1, 1'b1, 16'h8000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 16'h9048}, // R6 enable rise
    '{1'b1, 1'b0, 16'h8000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 16'h1048}, // R6 clear sw
    '{1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 16'h1048}, // R6 hold, no retrigger
    '{1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 16'h1048}, // R6 enable off
    '{1'b1, 1'b1, 16'h8000, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 16'h9048}, // R6 second rise
    '{1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b0, 3'b010, 1'b0, 1'b0, 16'h0020}, // R5 event beats clear
    '{1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 16'h0000}  // R4 clear all
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic quiet();
    host_wr = 1'b0; host_addr = A_STS; host_wdata = '0;
    mberr_pulse = 1'b0; sberr_pulse = 1'b0; gpio_pulse = '0; tmr_wrap = 1'b0; soft_rst = 1'b0;
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    tick();
    quiet();
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
    host_addr = A_STS;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #400us;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [31:0] rd;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_reg(A_STS, rd); check("R1 status after reset", rd, 32'h0);
    rd_reg(A_EN, rd);  check("R1 enable after reset", rd, 32'h0);
    check("R1 irq after reset", {31'h0, irq_out}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      host_wr = VECS[k].wr; host_addr = VECS[k].to_en ? A_EN : A_STS;
      host_wdata = {16'h0, VECS[k].wd};
      mberr_pulse = VECS[k].mb; sberr_pulse = VECS[k].sb; gpio_pulse = VECS[k].gp;
      tmr_wrap = VECS[k].tmr; phy_irq = VECS[k].phy;
      tick();
      quiet();
      tick();
      #1;
      check($sformatf("R3/R4/R5/R6/R7 vector %0d", k), host_rdata, {16'h0, VECS[k].exp});
    end

    // R2 reserved bits stay zero, enable mask
    wr_reg(A_STS, 32'hFFFF_FFFF);
    rd_reg(A_STS, rd); check("R2 reserved status bits", rd, 32'h0);
    wr_reg(A_EN, 32'hFFFF_FFFF);
    rd_reg(A_EN, rd); check("R2 enable readback mask", rd, 32'h0000_B07C);

    // R6 exact cycle of software bit
    wr_reg(A_EN, 32'h0);
    wr_reg(A_STS, 32'hFFFF);
    host_wr = 1'b1; host_addr = A_EN; host_wdata = 32'h8000;
    tick(); quiet();
    rd_reg(A_STS, rd); check("R6 not yet set one edge after write", rd, 32'h0);
    tick();
    rd_reg(A_STS, rd); check("R6 set second edge after write", rd, 32'h8000);
    wr_reg(A_STS, 32'h8000);

    // R9 irq lag and masking
    wr_reg(A_EN, 32'h0008);
    tmr_wrap = 1'b1; tick(); tmr_wrap = 1'b0;
    check("R9 irq low on latch edge", {31'h0, irq_out}, 32'h0);
    tick();
    check("R9 irq high one edge later", {31'h0, irq_out}, 32'h1);
    wr_reg(A_STS, 32'h0008);
    check("R9 irq still high on clear edge", {31'h0, irq_out}, 32'h1);
    tick();
    check("R9 irq low after clear", {31'h0, irq_out}, 32'h0);
    wr_reg(A_EN, 32'h0004);
    tmr_wrap = 1'b1; tick(); tmr_wrap = 1'b0; tick();
    check("R9 masked timer no irq", {31'h0, irq_out}, 32'h0);
    phy_irq = 1'b1; tick();
    check("R9 R7 phy level drives irq", {31'h0, irq_out}, 32'h1);
    phy_irq = 1'b0; tick();
    check("R9 R7 irq follows phy drop", {31'h0, irq_out}, 32'h0);

    // R8 soft reset clears bus errors only, wins over same-cycle error
    mberr_pulse = 1'b1; sberr_pulse = 1'b1; gpio_pulse = 3'b001; tick(); quiet();
    rd_reg(A_STS, rd); check("R3 errors latched", rd, 32'h3018);
    soft_rst = 1'b1; mberr_pulse = 1'b1; tick(); quiet();
    rd_reg(A_STS, rd); check("R8 soft reset clears bus errors", rd, 32'h0018);

    // R10 unmapped address
    wr_reg(12'h0D0, 32'hFFFF_FFFF);
    rd_reg(A_STS, rd); check("R10 unmapped write ignored status", rd, 32'h0018);
    rd_reg(A_EN, rd);  check("R10 unmapped write ignored enable", rd, 32'h0004);
    rd_reg(12'h0D0, rd); check("R10 unmapped read zero", rd, 32'h0);

    done = 1'b1;
    summary();
  end
endmodule